// File: doc/BRIEF.md
# Pointer-Indirect Buffer Access Port

This block gives a host processor byte-wide, register-indirect access to a 2048-byte on-chip packet buffer. The host never sees a memory bus. It writes an upper pointer byte that carries the transfer direction, an auto-advance enable and the top three address bits. It then writes a lower pointer byte, and that write loads the full 11-bit pointer. After that the host reads or writes a single data register as many times as the transfer needs.

In read direction the block fetches the addressed byte ahead of time into a staging register, so a data read returns at once. In write direction a data write lands in the same staging register and is stored into the buffer later. Host cycles therefore never stall on the buffer.

The buffer is shared with a network-side requester through a fixed-priority arbiter, and the network side always wins. A half-rate arbitration mode grants the buffer only on every second clock. A busy output tells the host when a prefetch or a staged write is still outstanding.

Top module: `bufport_top`

## Requirements
- R1: After reset the pointer reads back as zero at offsets 2 and 3, the data register at offset 4 reads zero, and busy is low.
- R2: A write to offset 2 alone leaves the pointer unchanged. The next write to offset 3 loads the pointer with address bits 10:8 from bits 2:0 of the offset-2 byte and bits 7:0 from the offset-3 byte. Offset 2 reads back {read-direction, auto-advance, bits 5:3 as written, pointer[10:8]}, and offset 3 reads back pointer[7:0].
- R3: When the pointer is loaded with bit 7 of the upper byte set (read direction), busy is high in the next cycle. Once busy falls, a data read returns the buffer byte at the pointer.
- R4: In read direction with bit 6 of the upper byte set (auto-advance), each data read advances the pointer by one and prefetches the following byte. Successive reads therefore return consecutive bytes, and the pointer readback counts them.
- R5: In read direction with auto-advance clear, repeated data reads return the same byte and the pointer does not move.
- R6: In write direction (bit 7 clear), a data write is stored into the buffer at the pointer. With auto-advance set, the pointer then advances by one.
- R7: The pointer wraps from 0x7FF to 0x000 on advance.
- R8: A data write in write direction while a previous staged write is still uncommitted (busy high) is dropped: the buffer keeps the first value and the pointer does not move.
- R9: A staged write is committed before any prefetch. A write, followed by a reload in read direction to the same address, reads back the written value.
- R10: The network requester has priority. While it requests, it is granted whenever the arbiter is enabled, the host stays busy, and a grant is never given without a request.
- R11: With half-rate arbitration selected, grants never occur in two consecutive cycles, so a held network request is granted every second cycle.
- R12: Busy rises only after a host register write or data read. With no host access, an idle block stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_slow_arb | input | 1 | Selects half-rate buffer arbitration |
| hst_wr | input | 1 | Host register write strobe |
| hst_rd | input | 1 | Host register read strobe (triggers read side effects) |
| hst_addr | input | 3 | Host register offset: 2 upper pointer, 3 lower pointer, 4 data |
| hst_wdata | input | 8 | Host write data |
| hst_rdata | output | 8 | Host read data for the offset on hst_addr |
| busy | output | 1 | Prefetch or staged write outstanding |
| net_req | input | 1 | Network-side buffer request, held until granted |
| net_we | input | 1 | Network-side write enable |
| net_addr | input | 11 | Network-side buffer address |
| net_wdata | input | 8 | Network-side write data |
| net_gnt | output | 1 | Network-side grant; the access happens at the end of this cycle |
| net_rdata | output | 8 | Network-side read data, valid the cycle after a read grant |

## Verification
A corrupt pointer shows up as a wrong readback at offsets 2 and 3 immediately after the load or advance. It also shows up as a wrong byte on the next data read, within the few cycles a prefetch takes. A lost or misordered staged write only appears when the buffer is read back through the network port, or after a reload in read direction. For that reason, each write scenario ends with such a readback. Arbitration faults appear within one cycle on the grant output or as a busy flag that clears while the network side still holds the buffer.

// File: rtl/bufport_pkg.sv
package bufport_pkg;

    localparam int BYTE_W  = 8;
    localparam int PTR_W   = 11;
    localparam int DEPTH   = 1 << PTR_W;
    localparam int HI_W    = PTR_W - BYTE_W;
    localparam int OFS_W   = 3;

    localparam logic [OFS_W-1:0] OFS_PHI = 3'd2;
    localparam logic [OFS_W-1:0] OFS_PLO = 3'd3;
    localparam logic [OFS_W-1:0] OFS_DAT = 3'd4;

    localparam int BIT_RDIR = 7;
    localparam int BIT_AINC = 6;

    typedef logic [PTR_W-1:0]  addr_t;
    typedef logic [BYTE_W-1:0] byte_t;

    typedef struct packed {
        logic  req;
        logic  we;
        addr_t addr;
        byte_t wdata;
    } mem_req_t;

    function automatic addr_t ptr_step(addr_t p);
        return p + addr_t'(1);
    endfunction

endpackage

// File: rtl/bufport_ram.sv
module bufport_ram #(
    parameter int AW = bufport_pkg::PTR_W,
    parameter int DW = bufport_pkg::BYTE_W
) (
    input  logic          clk,
    input  logic          en,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int WORDS = 1 << AW;

    logic [DW-1:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (en) begin
            if (we) begin
                mem[addr] <= wdata;
            end else begin
                rdata <= mem[addr];
            end
        end
    end

endmodule

// File: rtl/bufport_arb.sv
module bufport_arb (
    input  logic clk,
    input  logic rst,
    input  logic slow,
    input  logic net_req,
    input  logic host_req,
    output logic net_gnt,
    output logic host_gnt
);
    logic phase;
    logic slot;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= 1'b0;
        end else begin
            phase <= ~phase;
        end
    end

    // a grant slot every cycle, or every other cycle in half-rate mode
    assign slot     = ~slow | phase;
    assign net_gnt  = slot & net_req;
    assign host_gnt = slot & host_req & ~net_req;

endmodule

// File: rtl/bufport_host.sv
module bufport_host
    import bufport_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic             rd,
    input  logic [OFS_W-1:0] ofs,
    input  byte_t            wdata,
    output byte_t            rdata,
    output logic             busy,
    output mem_req_t         mreq,
    input  logic             gnt,
    input  byte_t            mem_dout
);
    byte_t hi_shadow;
    logic  rd_dir;
    logic  auto_inc;
    addr_t ptr;
    addr_t commit_addr;
    byte_t stage;
    logic  stage_ok;
    logic  need_fetch;
    logic  fetch_q;
    logic  pend;

    logic wr_hi, wr_lo, dat_wr, dat_rd;

    assign wr_hi  = wr && (ofs == OFS_PHI);
    assign wr_lo  = wr && (ofs == OFS_PLO);
    assign dat_wr = wr && (ofs == OFS_DAT) && !rd_dir && !pend;
    assign dat_rd = rd && (ofs == OFS_DAT) && rd_dir && stage_ok
                    && !need_fetch && !fetch_q;

    // commit first, prefetch only when nothing is in flight
    always_comb begin
        mreq.req   = pend | (need_fetch & ~fetch_q);
        mreq.we    = pend;
        mreq.addr  = pend ? commit_addr : ptr;
        mreq.wdata = stage;
    end

    assign busy = pend | need_fetch | fetch_q;

    always_comb begin
        unique case (ofs)
            OFS_PHI: rdata = {rd_dir, auto_inc, hi_shadow[5:HI_W], ptr[PTR_W-1:BYTE_W]};
            OFS_PLO: rdata = ptr[BYTE_W-1:0];
            OFS_DAT: rdata = stage;
            default: rdata = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_shadow   <= '0;
            rd_dir      <= 1'b0;
            auto_inc    <= 1'b0;
            ptr         <= '0;
            commit_addr <= '0;
            stage       <= '0;
            stage_ok    <= 1'b0;
            need_fetch  <= 1'b0;
            fetch_q     <= 1'b0;
            pend        <= 1'b0;
        end else begin
            fetch_q <= gnt & ~pend;
            if (gnt && pend) begin
                pend <= 1'b0;
            end
            if (gnt && !pend) begin
                need_fetch <= 1'b0;
            end
            // a fetch made stale by a later reload is discarded
            if (fetch_q && !need_fetch && rd_dir) begin
                stage    <= mem_dout;
                stage_ok <= 1'b1;
            end
            if (wr_hi) begin
                hi_shadow <= wdata;
            end
            if (wr_lo) begin
                ptr        <= {hi_shadow[HI_W-1:0], wdata};
                rd_dir     <= hi_shadow[BIT_RDIR];
                auto_inc   <= hi_shadow[BIT_AINC];
                need_fetch <= hi_shadow[BIT_RDIR];
                stage_ok   <= 1'b0;
            end
            if (dat_rd && auto_inc) begin
                ptr        <= ptr_step(ptr);
                need_fetch <= 1'b1;
                stage_ok   <= 1'b0;
            end
            if (dat_wr) begin
                stage       <= wdata;
                pend        <= 1'b1;
                commit_addr <= ptr;
                if (auto_inc) begin
                    ptr <= ptr_step(ptr);
                end
            end
        end
    end

endmodule

// File: rtl/bufport_top.sv
module bufport_top
    import bufport_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_slow_arb,
    input  logic        hst_wr,
    input  logic        hst_rd,
    input  logic [2:0]  hst_addr,
    input  logic [7:0]  hst_wdata,
    output logic [7:0]  hst_rdata,
    output logic        busy,
    input  logic        net_req,
    input  logic        net_we,
    input  logic [10:0] net_addr,
    input  logic [7:0]  net_wdata,
    output logic        net_gnt,
    output logic [7:0]  net_rdata
);
    mem_req_t host_mreq;
    logic     host_gnt;
    logic     ram_en;
    logic     ram_we;
    addr_t    ram_addr;
    byte_t    ram_wdata;
    byte_t    ram_dout;

    bufport_host u_host (
        .clk      (clk),
        .rst      (rst),
        .wr       (hst_wr),
        .rd       (hst_rd),
        .ofs      (hst_addr),
        .wdata    (hst_wdata),
        .rdata    (hst_rdata),
        .busy     (busy),
        .mreq     (host_mreq),
        .gnt      (host_gnt),
        .mem_dout (ram_dout)
    );

    bufport_arb u_arb (
        .clk      (clk),
        .rst      (rst),
        .slow     (cfg_slow_arb),
        .net_req  (net_req),
        .host_req (host_mreq.req),
        .net_gnt  (net_gnt),
        .host_gnt (host_gnt)
    );

    always_comb begin
        ram_en    = net_gnt | host_gnt;
        ram_we    = net_gnt ? net_we    : host_mreq.we;
        ram_addr  = net_gnt ? net_addr  : host_mreq.addr;
        ram_wdata = net_gnt ? net_wdata : host_mreq.wdata;
    end

    bufport_ram #(.AW(PTR_W), .DW(BYTE_W)) u_ram (
        .clk   (clk),
        .en    (ram_en),
        .we    (ram_we),
        .addr  (ram_addr),
        .wdata (ram_wdata),
        .rdata (ram_dout)
    );

    assign net_rdata = ram_dout;

endmodule

// File: rtl/bufport_chk.sv
module bufport_chk (
    input logic clk,
    input logic rst,
    input logic cfg_slow_arb,
    input logic hst_wr,
    input logic hst_rd,
    input logic busy,
    input logic net_req,
    input logic net_gnt
);
    // R1
    reset_idle_chk: assert property (@(posedge clk) rst |=> !busy);

    // R10
    gnt_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
        net_gnt |-> net_req);

    // R10
    net_first_chk: assert property (@(posedge clk) disable iff (rst)
        (net_req && !cfg_slow_arb) |-> net_gnt);

    // R11
    half_rate_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_slow_arb && net_gnt) |=> !net_gnt);

    // R12
    idle_stays_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !hst_wr && !hst_rd) |=> !busy);

endmodule

bind bufport_top bufport_chk i_chk (
    .clk          (clk),
    .rst          (rst),
    .cfg_slow_arb (cfg_slow_arb),
    .hst_wr       (hst_wr),
    .hst_rd       (hst_rd),
    .busy         (busy),
    .net_req      (net_req),
    .net_gnt      (net_gnt)
);

// File: tb/test_bufport_top.sv
module test_bufport_top;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_slow_arb;
    logic        hst_wr, hst_rd;
    logic [2:0]  hst_addr;
    logic [7:0]  hst_wdata;
    logic [7:0]  hst_rdata;
    logic        busy;
    logic        net_req, net_we;
    logic [10:0] net_addr;
    logic [7:0]  net_wdata;
    logic        net_gnt;
    logic [7:0]  net_rdata;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #(CLK_P/2) clk = ~clk;

    bufport_top i_bufport_top (
        .clk(clk), .rst(rst), .cfg_slow_arb(cfg_slow_arb),
        .hst_wr(hst_wr), .hst_rd(hst_rd), .hst_addr(hst_addr),
        .hst_wdata(hst_wdata), .hst_rdata(hst_rdata), .busy(busy),
        .net_req(net_req), .net_we(net_we), .net_addr(net_addr),
        .net_wdata(net_wdata), .net_gnt(net_gnt), .net_rdata(net_rdata)
    );

    function automatic logic [7:0] pat(logic [10:0] a);
        return a[7:0] ^ {5'b0, a[10:8]} ^ 8'hA5;
    endfunction

    task automatic check(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // all tasks start and end just after a falling edge
    task automatic reg_wr(logic [2:0] a, logic [7:0] d);
        hst_addr = a; hst_wdata = d; hst_wr = 1'b1;
        @(negedge clk);
        hst_wr = 1'b0;
    endtask

    task automatic reg_rd(logic [2:0] a, output logic [7:0] d);
        hst_addr = a; hst_rd = 1'b1;
        #1 d = hst_rdata;
        @(negedge clk);
        hst_rd = 1'b0;
    endtask

    task automatic peek(logic [2:0] a, output logic [7:0] d);
        hst_addr = a;
        #1 d = hst_rdata;
    endtask

    task automatic wait_idle(string tag);
        int n = 0;
        #1;
        while (busy && n < 50) begin
            @(negedge clk); #1; n++;
        end
        check(!busy, tag, busy, 0);
        @(negedge clk);
    endtask

    task automatic net_access(bit we, logic [10:0] a, logic [7:0] d, output logic [7:0] q);
        bit g = 0;
        net_req = 1'b1; net_we = we; net_addr = a; net_wdata = d;
        while (!g) begin
            #1 g = net_gnt;
            @(negedge clk);
        end
        net_req = 1'b0;
        #1 q = net_rdata;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        peek(3'd2, v); check(v == 8'h00, "R1 ptr hi", v, 0);
        peek(3'd3, v); check(v == 8'h00, "R1 ptr lo", v, 0);
        peek(3'd4, v); check(v == 8'h00, "R1 data", v, 0);
        check(!busy, "R1 busy", busy, 0);
    endtask

    task automatic t_prefill();
        logic [7:0] q;
        for (int i = 0; i < 8; i++) net_access(1'b1, 11'h100 + 11'(i), pat(11'h100 + 11'(i)), q);
        net_access(1'b1, 11'h7FF, pat(11'h7FF), q);
        net_access(1'b1, 11'h000, pat(11'h000), q);
        @(negedge clk);
    endtask

    task automatic t_load();
        logic [7:0] v;
        reg_wr(3'd2, 8'h05);
        peek(3'd3, v); check(v == 8'h00, "R2 lo after hi only", v, 0);
        peek(3'd2, v); check(v == 8'h00, "R2 hi after hi only", v, 0);
        reg_wr(3'd3, 8'h3C);
        peek(3'd3, v); check(v == 8'h3C, "R2 lo loaded", v, 8'h3C);
        peek(3'd2, v); check(v == 8'h05, "R2 hi loaded", v, 8'h05);
    endtask

    task automatic t_read_ainc();
        logic [7:0] v;
        reg_wr(3'd2, 8'hC1);
        reg_wr(3'd3, 8'h00);
        check(busy, "R3 busy after load", busy, 1);
        wait_idle("R3 prefetch done");
        for (int i = 0; i < 4; i++) begin
            reg_rd(3'd4, v);
            check(v == pat(11'h100 + 11'(i)), "R4 sequential byte", v, pat(11'h100 + 11'(i)));
            wait_idle("R4 next prefetch");
        end
        peek(3'd3, v); check(v == 8'h04, "R4 pointer count", v, 4);
    endtask

    task automatic t_read_noinc();
        logic [7:0] v;
        reg_wr(3'd2, 8'h81);
        reg_wr(3'd3, 8'h02);
        wait_idle("R5 prefetch");
        for (int i = 0; i < 3; i++) begin
            reg_rd(3'd4, v);
            check(v == pat(11'h102), "R5 same byte", v, pat(11'h102));
        end
        peek(3'd3, v); check(v == 8'h02, "R5 pointer held", v, 2);
    endtask

    task automatic t_write();
        logic [7:0] v, q;
        reg_wr(3'd2, 8'h41);
        reg_wr(3'd3, 8'h20);
        reg_wr(3'd4, 8'h11);
        wait_idle("R6 commit 1");
        reg_wr(3'd4, 8'h22);
        wait_idle("R6 commit 2");
        peek(3'd3, v); check(v == 8'h22, "R6 pointer advanced", v, 8'h22);
        net_access(1'b0, 11'h120, 8'h00, q); check(q == 8'h11, "R6 byte 0", q, 8'h11);
        net_access(1'b0, 11'h121, 8'h00, q); check(q == 8'h22, "R6 byte 1", q, 8'h22);
        @(negedge clk);
    endtask

    task automatic t_write_busy();
        logic [7:0] v, q;
        reg_wr(3'd2, 8'h01);
        reg_wr(3'd3, 8'h30);
        reg_wr(3'd4, 8'h5A);
        reg_wr(3'd4, 8'h66);
        wait_idle("R8 commit");
        peek(3'd3, v); check(v == 8'h30, "R8 pointer unchanged", v, 8'h30);
        net_access(1'b0, 11'h130, 8'h00, q); check(q == 8'h5A, "R8 first write kept", q, 8'h5A);
        @(negedge clk);
    endtask

    task automatic t_order_priority();
        logic [7:0] v;
        net_req = 1'b1; net_we = 1'b0; net_addr = 11'h000;
        reg_wr(3'd2, 8'h01);
        reg_wr(3'd3, 8'h40);
        reg_wr(3'd4, 8'h77);
        reg_wr(3'd2, 8'h81);
        reg_wr(3'd3, 8'h40);
        for (int i = 0; i < 4; i++) begin
            #1;
            check(busy, "R10 host held off", busy, 1);
            check(net_gnt, "R10 network granted", net_gnt, 1);
            @(negedge clk);
        end
        net_req = 1'b0;
        wait_idle("R9 commit then fetch");
        reg_rd(3'd4, v); check(v == 8'h77, "R9 commit before prefetch", v, 8'h77);
    endtask

    task automatic t_wrap();
        logic [7:0] v;
        reg_wr(3'd2, 8'hC7);
        reg_wr(3'd3, 8'hFF);
        wait_idle("R7 prefetch");
        reg_rd(3'd4, v); check(v == pat(11'h7FF), "R7 last byte", v, pat(11'h7FF));
        wait_idle("R7 refetch");
        peek(3'd3, v); check(v == 8'h00, "R7 lo wrapped", v, 0);
        peek(3'd2, v); check(v == 8'hC0, "R7 hi wrapped", v, 8'hC0);
        reg_rd(3'd4, v); check(v == pat(11'h000), "R7 first byte", v, pat(11'h000));
        wait_idle("R7 tail");
    endtask

    task automatic t_slow();
        logic [7:0] v;
        int n;
        cfg_slow_arb = 1'b1;
        net_req = 1'b1; net_we = 1'b0; net_addr = 11'h001;
        n = 0;
        for (int i = 0; i < 10; i++) begin
            #1 if (net_gnt) n++;
            @(negedge clk);
        end
        net_req = 1'b0;
        check(n == 5, "R11 half-rate grants", n, 5);
        reg_wr(3'd2, 8'h81);
        reg_wr(3'd3, 8'h03);
        wait_idle("R11 slow prefetch");
        reg_rd(3'd4, v); check(v == pat(11'h103), "R11 slow read", v, pat(11'h103));
        cfg_slow_arb = 1'b0;
        net_req = 1'b1;
        n = 0;
        for (int i = 0; i < 10; i++) begin
            #1 if (net_gnt) n++;
            @(negedge clk);
        end
        net_req = 1'b0;
        check(n == 10, "R10 full-rate grants", n, 10);
    endtask

    task automatic t_idle();
        for (int i = 0; i < 6; i++) begin
            #1 check(!busy, "R12 idle stays idle", busy, 0);
            @(negedge clk);
        end
    endtask

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog act=%0h exp=%0h", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; cfg_slow_arb = 1'b0;
        hst_wr = 1'b0; hst_rd = 1'b0; hst_addr = '0; hst_wdata = '0;
        net_req = 1'b0; net_we = 1'b0; net_addr = '0; net_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_idle();
        t_prefill();
        t_load();
        t_read_ainc();
        t_read_noinc();
        t_write();
        t_write_busy();
        t_order_priority();
        t_wrap();
        t_slow();
        t_idle();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule